// File: doc/BRIEF.md
# Redundant Reference Clock Failure Switch Controller

This block supervises two reference clocks for a clock tree that must survive the loss of one source. Each reference is oversampled by a faster, free-running system clock. A per-input counter measures how long the sampled reference has held one level. When that time exceeds a programmed limit, the input is declared dead and a sticky bad flag is raised. The limit is given in system-clock cycles and is normally set near the reference's nominal period.

The block keeps a one-bit selection of the active reference. In automatic mode, a failure of the selected input moves the selection to the other input, but only if that input is still healthy. The new selection is then held until an alarm clear, even if the failed input recovers. A manual hold input disables automatic switching and makes the selection follow the select pin directly. The active-low alarm clear wipes both flags and reloads the selection from the select pin. Downstream logic uses the selection indicator to steer its clock mux, and uses the flags for fault reporting.

Top module: `refclk_guard`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, both bad flags are cleared and `using_ref1` loads `pick_in1` (0 selects reference 0, 1 selects reference 1).
- R2: A reference that changes level at least once every `limit` system-clock cycles is never flagged bad.
- R3: A reference held at a constant level raises its bad flag no earlier than `limit`+1 and no later than `limit`+6 cycles after its last level change. This applies both to a reference stuck high and to one stuck low.
- R4: Once set, a bad flag stays high while `alarm_clr_n` is high, even after the reference resumes toggling.
- R5: While `alarm_clr_n` is low, both bad flags are cleared and `using_ref1` loads `pick_in1`.
- R6: With `manual_hold` low, the block switches to the other reference on the cycle after the currently selected reference is flagged bad, provided the other reference is not flagged.
- R7: When both references are flagged bad, the selection does not change.
- R8: In automatic mode, the selection changes only by failover (R6) or by a reset load (R1, R5). A change on `pick_in1` alone is ignored, and a recovered reference does not win the selection back.
- R9: With `manual_hold` high, `using_ref1` follows `pick_in1` one cycle later and no failover occurs, while the bad flags still report failures.
- R10: A failure of the reference that is not selected raises its flag and leaves the selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Synchronous active-low module reset |
| ref0_smp | input | 1 | Reference clock 0, raw level |
| ref1_smp | input | 1 | Reference clock 1, raw level |
| pick_in1 | input | 1 | Select pin: 0 selects reference 0, 1 selects reference 1 |
| manual_hold | input | 1 | 1 disables automatic failover |
| alarm_clr_n | input | 1 | Synchronous active-low alarm clear |
| limit0 | input | CNT_W | Stuck-level limit for reference 0, in clk cycles |
| limit1 | input | CNT_W | Stuck-level limit for reference 1, in clk cycles |
| ref0_bad | output | 1 | Sticky failure flag for reference 0 |
| ref1_bad | output | 1 | Sticky failure flag for reference 1 |
| using_ref1 | output | 1 | Selection indicator: 0 means reference 0, 1 means reference 1 |

## Verification
Several rules are checked by assertions on every cycle: flags are sticky and cleared by the alarm clear, a level change never lets the hold counter keep growing, and the selection follows the pin under manual hold. The assertions also check that failover fires exactly when the selected input is bad and the other is healthy, and that the selection stays put in every other automatic-mode case. Other behaviour shows only in the bench's directed scenarios. Those scenarios check the detection window relative to a real stuck waveform at both levels, and confirm that healthy toggling never raises a flag. They also confirm that a recovered input does not regain the selection, and that the reset and the alarm clear reload the selection from the pin.

// File: rtl/refclk_guard_pkg.sv
package refclk_guard_pkg;

  localparam int unsigned NUM_REFS = 2;

  // Next value of a hold counter: cleared on a level change, else saturating count.
  function automatic logic [31:0] hold_next(input logic [31:0] cur,
                                            input logic        changed,
                                            input logic [31:0] ceiling);
    if (changed)          return 32'd0;
    else if (cur >= ceiling) return ceiling;
    else                  return cur + 32'd1;
  endfunction

  // An input is dead once its hold time has gone past the limit.
  function automatic logic past_limit(input logic [31:0] held,
                                      input logic [31:0] lim);
    return held > lim;
  endfunction

endpackage

// File: rtl/rcg_sync.sv
module rcg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic toggled
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], din};
  end

  assign lvl     = pipe[STAGES-1];
  assign toggled = pipe[STAGES-1] ^ pipe[STAGES];

endmodule

// File: rtl/rcg_stuck_mon.sv
module rcg_stuck_mon
  import refclk_guard_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alarm_clr_n,
  input  logic             toggled,
  input  logic [CNT_W-1:0] limit,
  output logic             bad
);
  localparam logic [31:0] CEIL = (CNT_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT_W) - 32'd1);

  logic [CNT_W-1:0] held;
  logic             expired;

  assign expired = past_limit(32'(held), 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n || !alarm_clr_n) begin
      held <= '0;
      bad  <= 1'b0;
    end else begin
      held <= CNT_W'(hold_next(32'(held), toggled, CEIL));
      bad  <= bad | expired;
    end
  end

  // R4: a raised flag survives while no alarm clear is applied
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && alarm_clr_n) |=> bad);

  // R5: alarm clear empties the flag
  a_r5_alarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_clr_n |=> !bad);

  // R2: a level change restarts the hold time
  a_r2_change_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    toggled |=> (held == '0));

  // R3: a flag can only rise after the hold counter went past the limit
  a_r3_rise_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && alarm_clr_n && !expired) |=> !bad);

endmodule

// File: rtl/rcg_select.sv
module rcg_select (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm_clr_n,
  input  logic manual_hold,
  input  logic pick_in1,
  input  logic bad0,
  input  logic bad1,
  output logic sel1
);
  logic cur_bad;
  logic alt_bad;
  logic fail_over;

  assign cur_bad   = sel1 ? bad1 : bad0;
  assign alt_bad   = sel1 ? bad0 : bad1;
  assign fail_over = !manual_hold && cur_bad && !alt_bad;

  always_ff @(posedge clk) begin
    if (!rst_n || !alarm_clr_n) sel1 <= pick_in1;
    else if (manual_hold)       sel1 <= pick_in1;
    else if (fail_over)         sel1 <= ~sel1;
  end

  // R9: manual hold makes the selection track the pin
  a_r9_hold_tracks_pin: assert property (@(posedge clk) disable iff (!rst_n)
    manual_hold |=> (sel1 == $past(pick_in1)));

  // R6: selected input bad, other healthy -> switch
  a_r6_failover: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_clr_n && !manual_hold && (sel1 ? bad1 : bad0) && !(sel1 ? bad0 : bad1))
      |=> (sel1 != $past(sel1)));

  // R7: both bad -> selection frozen
  a_r7_both_bad_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_clr_n && !manual_hold && bad0 && bad1) |=> $stable(sel1));

  // R8: healthy selected input in automatic mode -> selection frozen
  a_r8_no_spurious_move: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_clr_n && !manual_hold && !(sel1 ? bad1 : bad0)) |=> $stable(sel1));

  // R5: alarm clear reloads from the pin
  a_r5_alarm_reload: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_clr_n |=> (sel1 == $past(pick_in1)));

endmodule

// File: rtl/refclk_guard.sv
module refclk_guard
  import refclk_guard_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref0_smp,
  input  logic             ref1_smp,
  input  logic             pick_in1,
  input  logic             manual_hold,
  input  logic             alarm_clr_n,
  input  logic [CNT_W-1:0] limit0,
  input  logic [CNT_W-1:0] limit1,
  output logic             ref0_bad,
  output logic             ref1_bad,
  output logic             using_ref1
);
  logic [NUM_REFS-1:0] raw;
  logic [NUM_REFS-1:0] lvl;
  logic [NUM_REFS-1:0] toggled;
  logic [NUM_REFS-1:0] bad;
  logic [CNT_W-1:0]    lim [NUM_REFS];

  assign raw    = {ref1_smp, ref0_smp};
  assign lim[0] = limit0;
  assign lim[1] = limit1;

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_ch
    rcg_sync #(.STAGES(SYNC_STGS)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (raw[i]),
      .lvl     (lvl[i]),
      .toggled (toggled[i])
    );

    rcg_stuck_mon #(.CNT_W(CNT_W)) u_mon (
      .clk         (clk),
      .rst_n       (rst_n),
      .alarm_clr_n (alarm_clr_n),
      .toggled     (toggled[i]),
      .limit       (lim[i]),
      .bad         (bad[i])
    );
  end

  rcg_select u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .alarm_clr_n (alarm_clr_n),
    .manual_hold (manual_hold),
    .pick_in1    (pick_in1),
    .bad0        (bad[0]),
    .bad1        (bad[1]),
    .sel1        (using_ref1)
  );

  assign ref0_bad = bad[0];
  assign ref1_bad = bad[1];

  // R10: a fault on the unselected input never moves the selection
  a_r10_unselected_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_clr_n && !manual_hold && (using_ref1 ? !ref1_bad : !ref0_bad))
      |=> $stable(using_ref1));

  // R1: outputs are quiet right after reset
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!ref0_bad && !ref1_bad));

endmodule

// File: tb/refclk_guard_bench.sv
module refclk_guard_bench;
  localparam int CW  = 16;
  localparam int LIM = 20;
  localparam int HP  = 6;

  logic clk = 1'b0;
  logic rst_n, ref0, ref1, pick, hold, aclr_n;
  logic [CW-1:0] lim0, lim1;
  logic bad0, bad1, sel1;

  bit run0, run1, lvl0, lvl1;
  int c0, c1;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  refclk_guard #(.CNT_W(CW)) u_refclk_guard (
    .clk(clk), .rst_n(rst_n), .ref0_smp(ref0), .ref1_smp(ref1),
    .pick_in1(pick), .manual_hold(hold), .alarm_clr_n(aclr_n),
    .limit0(lim0), .limit1(lim1),
    .ref0_bad(bad0), .ref1_bad(bad1), .using_ref1(sel1));

  always @(negedge clk) begin
    if (run0) begin
      if (c0 >= HP - 1) begin ref0 <= ~ref0; c0 <= 0; end else c0 <= c0 + 1;
    end else ref0 <= lvl0;
    if (run1) begin
      if (c1 >= HP - 1) begin ref1 <= ~ref1; c1 <= 0; end else c1 <= c1 + 1;
    end else ref1 <= lvl1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic alarm_pulse();
    aclr_n = 1'b0; cyc(3); aclr_n = 1'b1; cyc(2);
  endtask

  task automatic t_reset();
    pick = 1'b1; rst_n = 1'b0; cyc(4);
    chk("R1 sel after reset pick=1", sel1, 1);
    chk("R1 bad0 after reset", bad0, 0);
    chk("R1 bad1 after reset", bad1, 0);
    pick = 1'b0; cyc(2);
    chk("R1 sel reloads pick=0", sel1, 0);
    rst_n = 1'b1; cyc(2);
  endtask

  task automatic t_healthy();
    cyc(200);
    chk("R2 healthy bad0", bad0, 0);
    chk("R2 healthy bad1", bad1, 0);
    chk("R2 healthy sel", sel1, 0);
  endtask

  task automatic t_pin_ignored();
    pick = 1'b1; cyc(10);
    chk("R8 pin ignored in auto", sel1, 0);
    pick = 1'b0; cyc(2);
  endtask

  task automatic t_unselected_fail();
    lvl1 = 1'b1; run1 = 1'b0;
    cyc(10);
    chk("R3 no early flag high-stuck", bad1, 0);
    cyc(30);
    chk("R3 stuck high flagged", bad1, 1);
    chk("R10 selection unchanged", sel1, 0);
    chk("R10 other flag clear", bad0, 0);
  endtask

  task automatic t_sticky();
    run1 = 1'b1; cyc(100);
    chk("R4 flag stays after recovery", bad1, 1);
  endtask

  task automatic t_alarm();
    pick = 1'b1; aclr_n = 1'b0; cyc(3);
    chk("R5 flags cleared", bad1, 0);
    chk("R5 sel follows pin", sel1, 1);
    pick = 1'b0; cyc(2);
    chk("R5 sel follows pin change", sel1, 0);
    aclr_n = 1'b1; cyc(100);
    chk("R5 flags stay clear", bad0 | bad1, 0);
  endtask

  task automatic t_failover();
    lvl0 = 1'b0; run0 = 1'b0;
    cyc(10);
    chk("R3 no early flag low-stuck", bad0, 0);
    cyc(30);
    chk("R3 stuck low flagged", bad0, 1);
    chk("R6 failover to ref1", sel1, 1);
  endtask

  task automatic t_hold_new();
    run0 = 1'b1; cyc(100);
    chk("R8 stays on ref1 after recovery", sel1, 1);
    chk("R4 bad0 still set", bad0, 1);
    alarm_pulse();
    chk("R5 reload to ref0", sel1, 0);
  endtask

  task automatic t_both_bad();
    lvl1 = 1'b0; run1 = 1'b0; cyc(40);
    chk("R10 ref1 bad no move", sel1, 0);
    lvl0 = 1'b1; run0 = 1'b0; cyc(40);
    chk("R7 both flagged bad0", bad0, 1);
    chk("R7 both flagged bad1", bad1, 1);
    chk("R7 selection frozen", sel1, 0);
    run0 = 1'b1; run1 = 1'b1; cyc(10);
    alarm_pulse(); cyc(20);
  endtask

  task automatic t_override();
    hold = 1'b1; pick = 1'b1; cyc(3);
    chk("R9 follows pin high", sel1, 1);
    pick = 1'b0; cyc(3);
    chk("R9 follows pin low", sel1, 0);
    lvl0 = 1'b0; run0 = 1'b0; cyc(40);
    chk("R9 flag still reported", bad0, 1);
    chk("R9 no failover", sel1, 0);
    run0 = 1'b1; hold = 1'b0; alarm_pulse();
  endtask

  initial begin
    rst_n = 1'b0; aclr_n = 1'b1; hold = 1'b0; pick = 1'b0;
    lim0 = CW'(LIM); lim1 = CW'(LIM);
    ref0 = 1'b0; ref1 = 1'b0; run0 = 1'b1; run1 = 1'b1;
    lvl0 = 1'b0; lvl1 = 1'b0; c0 = 0; c1 = 3;
    t_reset();
    t_healthy();
    t_pin_ignored();
    t_unselected_fail();
    t_sticky();
    t_alarm();
    t_failover();
    t_hold_new();
    t_both_bad();
    t_override();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule